// File: doc/BRIEF.md
# Instruction Fetch Breakpoint Unit

This debug block watches the retired-instruction stream of a processor core and raises a break request when an executed instruction's program counter hits one of its channels. The stream delivers at most one entry per cycle. Each entry carries a program counter and four flags: valid, executed, delayed branch and branch taken. Entries that were fetched but never executed, for example after a branch or an interrupt transition, are filtered out completely.

Each channel holds a compare address, a don't-care mask, an enable and a mode bit. The mode bit selects whether the break comes before or after the matched instruction. The break request is a one-cycle pulse. It comes with `brk_pc`, which is the address of the instruction that must not execute yet; the exception logic uses it as the resume address. Delayed branches shift that boundary. A pre-execution hit on a delay slot resumes at the branch. A post-execution hit on a taken delayed branch, or on its slot, waits until the branch destination. Each channel also has a sticky hit flag, which stays set until it is cleared.

Top module: `fetch_break_unit`

## Requirements
- R1: After synchronous reset, `brk_req` is 0, every `brk_status` bit is 0 and every channel is disabled.
- R2: A channel hits an entry with `in_valid`=1 and `in_exec`=1 when the channel is enabled and `in_pc` equals the compare address in every bit position where the mask bit is 0. A mask bit of 1 means don't care.
- R3: A channel whose compare address has bit 0 set to 1 never hits, whatever its mask.
- R4: An entry with `in_valid`=0 or `in_exec`=0 causes no hit, no break and no flag. It also does not change the delay-slot tracking or a pending post-execution break.
- R5: A pre-execution hit (`cfg_post`=0) on an instruction that is not a delay slot raises `brk_req` in the cycle after that entry, with `brk_pc` equal to that entry's pc.
- R6: A pre-execution hit on a delay-slot instruction raises `brk_req` in the cycle after the slot entry, with `brk_pc` equal to the pc of the delayed branch that owns the slot.
- R7: A post-execution hit (`cfg_post`=1) arms a pending break. The break fires in the cycle after the next executed entry that is not a delay slot, with `brk_pc` equal to that entry's pc.
- R8: A post-execution hit on a taken delayed branch, or on its delay slot, raises no break until the first executed instruction after the slot, which is the branch destination.
- R9: An executed entry is a delay slot only when the previous executed entry had `in_dbr`=1 and `in_taken`=1. After a delayed branch that is not taken, the next instruction is handled as an ordinary instruction.
- R10: `brk_status[i]` is set in the cycle after a hit on channel i. It stays set until `stat_clr[i]` is high at a clock edge with no new hit on that channel; a new hit wins over a clear.
- R11: When several channels hit the same entry, all of their flags are set and only one one-cycle `brk_req` pulse is issued.
- R12: A write with `cfg_wr`=1 loads the compare address, mask, enable and mode of channel `cfg_sel`. The new settings apply to entries from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Channel configuration write strobe |
| cfg_sel | input | CW | Channel index for the write |
| cfg_addr | input | AW | Compare address |
| cfg_mask | input | AW | Address mask, 1 = don't care |
| cfg_en | input | 1 | Channel enable |
| cfg_post | input | 1 | 1 = break after execution, 0 = before |
| stat_clr | input | NCH | Per-channel clear of the sticky flags |
| in_valid | input | 1 | Stream entry present |
| in_exec | input | 1 | Entry was actually executed |
| in_pc | input | AW | Entry program counter |
| in_dbr | input | 1 | Entry is a delayed branch |
| in_taken | input | 1 | Delayed branch was taken |
| brk_req | output | 1 | One-cycle break request |
| brk_pc | output | AW | Resume address for the break, valid with brk_req |
| brk_status | output | NCH | Sticky per-channel hit flags |

## Verification
The hardest case to reach from the ports is several timing rules meeting at once. One example is a post-execution hit armed on a taken branch, then a pre-execution hit on its slot, with non-executed entries in between that must not move the slot tracking. The directed sequences build these cases explicitly from branch and slot entries. A long random stream then draws from a small pool of addresses, with random branch, taken and executed flags, reprogrammed channels and random clears. This makes overlaps between pending and immediate breaks common, and a reference model checks every cycle.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  typedef enum logic {
    MODE_PRE  = 1'b0,
    MODE_POST = 1'b1
  } brk_mode_e;

  function automatic logic masked_equal(input logic [63:0] a, input logic [63:0] b,
                                        input logic [63:0] dont_care);
    return ((a ^ b) & ~dont_care) == 64'd0;
  endfunction
endpackage

// File: rtl/fbu_cfg_bank.sv
module fbu_cfg_bank
  import fbu_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32,
  parameter int CW  = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic [CW-1:0]           sel,
  input  logic [AW-1:0]           wr_addr,
  input  logic [AW-1:0]           wr_mask,
  input  logic                    wr_en,
  input  logic                    wr_post,
  output logic [NCH-1:0][AW-1:0]  ch_addr,
  output logic [NCH-1:0][AW-1:0]  ch_mask,
  output logic [NCH-1:0]          ch_en,
  output brk_mode_e [NCH-1:0]     ch_mode
);
  for (genvar g = 0; g < NCH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        ch_addr[g] <= '0;
        ch_mask[g] <= '0;
        ch_en[g]   <= 1'b0;
        ch_mode[g] <= MODE_PRE;
      end else if (wr && (sel == CW'(g))) begin
        ch_addr[g] <= wr_addr;
        ch_mask[g] <= wr_mask;
        ch_en[g]   <= wr_en;
        ch_mode[g] <= brk_mode_e'(wr_post);
      end
    end
  end
endmodule

// File: rtl/fbu_chan_match.sv
module fbu_chan_match
  import fbu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cmp_addr,
  input  logic [AW-1:0] cmp_mask,
  input  logic          en,
  input  brk_mode_e     mode,
  input  logic          ev,
  input  logic [AW-1:0] pc,
  output logic          hit,
  output logic          pre_hit,
  output logic          post_hit
);
  logic armed;
  logic addr_eq;

  always_comb begin
    armed    = en && !cmp_addr[0];
    addr_eq  = masked_equal(64'(pc), 64'(cmp_addr), 64'(cmp_mask));
    hit      = ev && armed && addr_eq;
    pre_hit  = hit && (mode == MODE_PRE);
    post_hit = hit && (mode == MODE_POST);
  end
endmodule

// File: rtl/fbu_slot_track.sv
module fbu_slot_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev,
  input  logic          dbr,
  input  logic          taken,
  input  logic [AW-1:0] pc,
  output logic          is_slot,
  output logic [AW-1:0] owner_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      is_slot  <= 1'b0;
      owner_pc <= '0;
    end else if (ev) begin
      is_slot <= dbr && taken;
      if (dbr && taken) owner_pc <= pc;
    end
  end
endmodule

// File: rtl/fbu_break_sched.sv
module fbu_break_sched #(
  parameter int NCH = 2,
  parameter int AW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ev,
  input  logic [AW-1:0]  pc,
  input  logic           is_slot,
  input  logic [AW-1:0]  owner_pc,
  input  logic [NCH-1:0] hit,
  input  logic [NCH-1:0] pre_hit,
  input  logic [NCH-1:0] post_hit,
  input  logic [NCH-1:0] clr,
  output logic           brk_req,
  output logic [AW-1:0]  brk_pc,
  output logic [NCH-1:0] status,
  output logic           pending
);
  logic any_pre;
  logic any_post;
  logic fire_pend;

  always_comb begin
    any_pre   = |pre_hit;
    any_post  = |post_hit;
    fire_pend = pending && ev && !is_slot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req <= 1'b0;
      brk_pc  <= '0;
      pending <= 1'b0;
      status  <= '0;
    end else begin
      brk_req <= any_pre || fire_pend;
      if (any_pre) brk_pc <= is_slot ? owner_pc : pc;
      else if (fire_pend) brk_pc <= pc;
      if (any_post) pending <= 1'b1;
      else if (fire_pend) pending <= 1'b0;
      status <= (status & ~clr) | hit;
    end
  end
endmodule

// File: rtl/fetch_break_unit.sv
module fetch_break_unit
  import fbu_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [CW-1:0]  cfg_sel,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [AW-1:0]  cfg_mask,
  input  logic           cfg_en,
  input  logic           cfg_post,
  input  logic [NCH-1:0] stat_clr,
  input  logic           in_valid,
  input  logic           in_exec,
  input  logic [AW-1:0]  in_pc,
  input  logic           in_dbr,
  input  logic           in_taken,
  output logic           brk_req,
  output logic [AW-1:0]  brk_pc,
  output logic [NCH-1:0] brk_status
);
  logic [NCH-1:0][AW-1:0] ch_addr;
  logic [NCH-1:0][AW-1:0] ch_mask;
  logic [NCH-1:0]         ch_en;
  brk_mode_e [NCH-1:0]    ch_mode;
  logic [NCH-1:0]         hit, pre_hit, post_hit;
  logic                   ev;
  logic                   slot_now;
  logic [AW-1:0]          owner_pc;
  logic                   pend;

  assign ev = in_valid && in_exec;

  fbu_cfg_bank #(.NCH(NCH), .AW(AW), .CW(CW)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .sel(cfg_sel),
    .wr_addr(cfg_addr), .wr_mask(cfg_mask), .wr_en(cfg_en), .wr_post(cfg_post),
    .ch_addr(ch_addr), .ch_mask(ch_mask), .ch_en(ch_en), .ch_mode(ch_mode)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    fbu_chan_match #(.AW(AW)) u_match (
      .cmp_addr(ch_addr[g]), .cmp_mask(ch_mask[g]), .en(ch_en[g]),
      .mode(ch_mode[g]), .ev(ev), .pc(in_pc),
      .hit(hit[g]), .pre_hit(pre_hit[g]), .post_hit(post_hit[g])
    );
  end

  fbu_slot_track #(.AW(AW)) u_slot (
    .clk(clk), .rst(rst), .ev(ev), .dbr(in_dbr), .taken(in_taken), .pc(in_pc),
    .is_slot(slot_now), .owner_pc(owner_pc)
  );

  fbu_break_sched #(.NCH(NCH), .AW(AW)) u_sched (
    .clk(clk), .rst(rst), .ev(ev), .pc(in_pc), .is_slot(slot_now),
    .owner_pc(owner_pc), .hit(hit), .pre_hit(pre_hit), .post_hit(post_hit),
    .clr(stat_clr), .brk_req(brk_req), .brk_pc(brk_pc), .status(brk_status),
    .pending(pend)
  );
endmodule

// File: rtl/fbu_checker.sv
module fbu_checker #(
  parameter int NCH = 2,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_exec,
  input logic [AW-1:0]  in_pc,
  input logic [NCH-1:0] stat_clr,
  input logic           brk_req,
  input logic [AW-1:0]  brk_pc,
  input logic [NCH-1:0] brk_status,
  input logic           slot_now
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!brk_req && brk_status == '0)); // R1

  AST_BREAK_NEEDS_EXEC: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> $past(in_valid && in_exec)); // R4

  AST_PLAIN_BREAK_PC: assert property (@(posedge clk) disable iff (rst)
    (brk_req && !$past(slot_now)) |-> (brk_pc == $past(in_pc))); // R5

  for (genvar g = 0; g < NCH; g++) begin : g_flag
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (brk_status[g] && !stat_clr[g]) |=> brk_status[g]); // R10

    AST_FLAG_NEEDS_EXEC: assert property (@(posedge clk) disable iff (rst)
      $rose(brk_status[g]) |-> $past(in_valid && in_exec)); // R4
  end
endmodule

bind fetch_break_unit fbu_checker #(.NCH(NCH), .AW(AW)) u_fbu_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_exec(in_exec), .in_pc(in_pc),
  .stat_clr(stat_clr), .brk_req(brk_req), .brk_pc(brk_pc),
  .brk_status(brk_status), .slot_now(slot_now)
);

// File: tb/test_fetch_break_unit.sv
`timescale 1ns/1ps
module test_fetch_break_unit;
  localparam int NCH = 2;
  localparam int AW  = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_wr = 1'b0;
  logic [0:0]     cfg_sel = '0;
  logic [AW-1:0]  cfg_addr = '0, cfg_mask = '0;
  logic           cfg_en = 1'b0, cfg_post = 1'b0;
  logic [NCH-1:0] stat_clr = '0;
  logic           in_valid = 1'b0, in_exec = 1'b0, in_dbr = 1'b0, in_taken = 1'b0;
  logic [AW-1:0]  in_pc = '0;
  logic           brk_req;
  logic [AW-1:0]  brk_pc;
  logic [NCH-1:0] brk_status;

  always #2.5 clk = ~clk;

  fetch_break_unit #(.NCH(NCH), .AW(AW)) i_fetch_break_unit (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_mask(cfg_mask), .cfg_en(cfg_en), .cfg_post(cfg_post), .stat_clr(stat_clr),
    .in_valid(in_valid), .in_exec(in_exec), .in_pc(in_pc), .in_dbr(in_dbr),
    .in_taken(in_taken), .brk_req(brk_req), .brk_pc(brk_pc), .brk_status(brk_status)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  bit          m_en[NCH];
  bit          m_post[NCH];
  bit [AW-1:0] m_addr[NCH];
  bit [AW-1:0] m_mask[NCH];
  bit          m_slot, m_pend, m_req;
  bit [AW-1:0] m_owner, m_bpc;
  bit [NCH-1:0] m_stat;

  task automatic check(string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: drive inputs, advance model, compare after the edge
  task automatic step(bit v, bit e, bit [AW-1:0] pc, bit d, bit t, bit [NCH-1:0] clr);
    bit ev, pre, post, fire;
    bit [NCH-1:0] h;
    in_valid = v; in_exec = e; in_pc = pc; in_dbr = d; in_taken = t; stat_clr = clr;
    ev = v && e;
    pre = 0; post = 0; h = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ev && m_en[c] && !m_addr[c][0] && (((pc ^ m_addr[c]) & ~m_mask[c]) == 0)) begin
        h[c] = 1;
        if (m_post[c]) post = 1; else pre = 1;
      end
    end
    fire = m_pend && ev && !m_slot;
    m_req = pre || fire;
    if (m_req) m_bpc = (pre && m_slot) ? m_owner : pc;
    if (post) m_pend = 1; else if (fire) m_pend = 0;
    m_stat = (m_stat & ~clr) | h;
    if (ev) begin
      if (d && t) m_owner = pc;
      m_slot = d && t;
    end
    if (cfg_wr) begin
      m_addr[cfg_sel] = cfg_addr; m_mask[cfg_sel] = cfg_mask;
      m_en[cfg_sel] = cfg_en; m_post[cfg_sel] = cfg_post;
    end
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    check("brk_req", brk_req, m_req);
    if (m_req) check("brk_pc", brk_pc, m_bpc);
    check("brk_status", brk_status, m_stat);
  endtask

  task automatic cfg(int ch, bit [AW-1:0] a, bit [AW-1:0] m, bit en, bit post);
    cfg_wr = 1; cfg_sel = ch[0:0]; cfg_addr = a; cfg_mask = m; cfg_en = en; cfg_post = post;
    step(0, 0, 0, 0, 0, '0);
  endtask

  task automatic ins(bit [AW-1:0] pc, bit d = 0, bit t = 0);
    step(1, 1, pc, d, t, '0);
  endtask

  task automatic clear_all();
    step(0, 0, 0, 0, 0, '1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_en[c] = 0; m_post[c] = 0; m_addr[c] = 0; m_mask[c] = 0;
    end
    m_slot = 0; m_pend = 0; m_req = 0; m_owner = 0; m_bpc = 0; m_stat = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, channels disabled so a stream raises nothing
    tag = "R1";
    check("brk_req", brk_req, 0);
    check("brk_status", brk_status, 0);
    ins(32'h0); ins(32'h100);

    // R12, R2, R5: exact and masked pre-execution matches
    tag = "R12";
    cfg(0, 32'h100, 32'h0, 1, 0);
    tag = "R5";
    ins(32'hFC); ins(32'h100); ins(32'h104);
    tag = "R2";
    cfg(1, 32'h200, 32'hF0, 1, 0);
    ins(32'h2A0); ins(32'h2A2); ins(32'h300);
    clear_all();

    // R3: lsb of compare address set blocks the channel
    tag = "R3";
    cfg(0, 32'h101, 32'h0, 1, 0);
    cfg(1, 32'h101, 32'h1, 1, 0);
    ins(32'h100); ins(32'h101); ins(32'h100);

    // R4: non-executed and invalid entries have no effect
    tag = "R4";
    cfg(0, 32'h400, 32'h0, 1, 0);
    cfg(1, 32'h0, 32'h0, 0, 0);
    step(1, 0, 32'h400, 0, 0, '0);
    step(0, 1, 32'h400, 0, 0, '0);
    ins(32'h3FE);
    step(1, 0, 32'h3F0, 1, 1, '0);   // discarded branch: no slot follows
    ins(32'h400);

    // R6: pre-execution hit on a delay slot resumes at the branch
    tag = "R6";
    clear_all();
    cfg(0, 32'h304, 32'h0, 1, 0);
    ins(32'h300, 1, 1); ins(32'h304); ins(32'h500);
    ins(32'h300, 1, 1); step(1, 0, 32'h888, 0, 0, '0); ins(32'h304); ins(32'h502);

    // R7: post-execution hit fires before the next executed instruction
    tag = "R7";
    cfg(0, 32'h0, 32'h0, 0, 0);
    cfg(1, 32'h400, 32'h0, 1, 1);
    ins(32'h400); step(0, 0, 0, 0, 0, '0); step(1, 0, 32'h990, 0, 0, '0); ins(32'h402);
    ins(32'h404);

    // R8: post hit on taken branch or slot waits for the destination
    tag = "R8";
    cfg(1, 32'h600, 32'h0, 1, 1);
    ins(32'h600, 1, 1); ins(32'h604); ins(32'h800); ins(32'h802);
    cfg(1, 32'h604, 32'h0, 1, 1);
    ins(32'h600, 1, 1); ins(32'h604); ins(32'h900); ins(32'h902);

    // R9: not-taken delayed branch leaves an ordinary successor
    tag = "R9";
    cfg(1, 32'h700, 32'h0, 1, 1);
    ins(32'h700, 1, 0); ins(32'h704); ins(32'h706);
    cfg(0, 32'h704, 32'h0, 1, 0);
    cfg(1, 32'h0, 32'h0, 0, 0);
    ins(32'h700, 1, 0); ins(32'h704); ins(32'h706);

    // R11: both channels on one entry give one pulse and two flags
    tag = "R11";
    clear_all();
    cfg(0, 32'hA00, 32'h0, 1, 0);
    cfg(1, 32'hA00, 32'hF, 1, 0);
    ins(32'hA00); ins(32'hA02); ins(32'hA10);

    // R10: flags sticky, cleared per bit, set wins over clear
    tag = "R10";
    step(0, 0, 0, 0, 0, 2'b01);
    step(0, 0, 0, 0, 0, 2'b00);
    step(1, 1, 32'hA00, 0, 0, 2'b11);
    step(0, 0, 0, 0, 0, 2'b10);

    // random stream: R2, R5, R6, R7, R8, R9, R10, R11 overlap
    tag = "R8";
    for (int blk = 0; blk < 20; blk++) begin
      for (int c = 0; c < NCH; c++)
        cfg(c, 32'h1000 + ($urandom % 16) * 2 + (($urandom % 8 == 0) ? 1 : 0),
            ($urandom % 3 == 0) ? 32'h6 : 32'h0, ($urandom % 5) != 0, $urandom % 2);
      for (int k = 0; k < 150; k++) begin
        bit d;
        d = ($urandom % 4) == 0;
        step(($urandom % 6) != 0, ($urandom % 5) != 0, 32'h1000 + ($urandom % 16) * 2,
             d, d && ($urandom % 3 != 0),
             (($urandom % 10) == 0) ? NCH'($urandom) : '0);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule